// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small set of hardware lock flags that two independent requesters, called left and right, use to coordinate ownership of a shared resource. Each side has its own strobe, enable, direction, address and single-bit write data. Address bits choose one flag. A flag access happens only when the semaphore strobe is active (low) and the memory enable is inactive (high). A side claims a flag by writing 0. It hands the flag back by writing 1. A read returns the flag's status as seen from the reading side, copied onto every data bit.

When one side asks for a flag that the other side holds, the request is not lost. The unit records it, and on release the token moves straight to the waiting side in the same clock edge. The flag does not pass through the free state, so no third party can step in between. A requester that no longer wants the flag can cancel its waiting request by writing 1. If both sides claim a free flag in the same cycle, the left side wins and the right side's claim stays queued.

Top module: `dual_sem_unit`

## Requirements
- R1: The unit holds 8 flags, selected by a 3-bit address. An access to one flag never changes the state of any other flag.
- R2: A flag access needs the strobe low and the memory enable high. A write additionally needs the direction input low, and a read needs it high. With the memory enable low or the strobe high, writes have no effect and the read data is all zeros.
- R3: Writing data bit 0 to a free flag gives that side the token from the next clock edge on.
- R4: Writing 0 to a flag the other side holds leaves the holder unchanged and records a pending request for the writer.
- R5: When the holder writes 1 while the other side has a pending request, or requests in that same cycle, the other side holds the token from the next edge.
- R6: When the holder writes 1 and the other side has no pending or same-cycle request, the flag becomes free.
- R7: During a read access, the 16-bit read data is all zeros when the reading side holds the addressed flag and all ones otherwise. This includes right after reset, when every flag is free.
- R8: Writing 1 to a flag the writer does not hold has no effect when the writer has no pending request. If the writer does have one, the write cancels it.
- R9: When both sides write 0 to the same free flag in the same cycle, the left side gets the token and the right side's request stays pending.
- R10: The holder writing 0 to its own flag changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; frees all flags |
| l_sel_n | input | 1 | Left semaphore strobe, active low |
| l_ce_n | input | 1 | Left memory enable, active low; must be high for a flag access |
| l_we_n | input | 1 | Left direction: low writes, high reads |
| l_addr | input | 3 | Left flag index |
| l_wbit | input | 1 | Left write data bit (0 claims, 1 releases) |
| l_rdata | output | 16 | Left read data (flag status on all bits) |
| r_sel_n | input | 1 | Right semaphore strobe, active low |
| r_ce_n | input | 1 | Right memory enable, active low; must be high for a flag access |
| r_we_n | input | 1 | Right direction: low writes, high reads |
| r_addr | input | 3 | Right flag index |
| r_wbit | input | 1 | Right write data bit (0 claims, 1 releases) |
| r_rdata | output | 16 | Right read data (flag status on all bits) |

## Verification
Directed sequences steer single flags through each transition:
- claim from free;
- blocked claim;
- release with a queued request, with a same-cycle request, and with no request;
- cancelled request;
- same-cycle tie.

Each sequence is confirmed by reads from both sides, which tells a direct handoff apart from a pass through the free state.

Accesses with the memory enable low are mixed in to show that they neither write nor read.

A long random phase then drives both sides at once, with addresses biased onto a few flags so that collisions are frequent. A reference model checks every read. That model separates per-flag independence from cross-talk between flags, and pending-request bookkeeping from plain ownership.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int SEM_FLAGS = 8;
    localparam int SEM_AW    = $clog2(SEM_FLAGS);
    localparam int SEM_DW    = 16;

    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_e;

    // Per-flag state: current holder plus a queued request for each side.
    typedef struct packed {
        tok_e holder;
        logic wait_l;
        logic wait_r;
    } flag_st_t;

    // Decoded write command from one side to one flag.
    typedef struct packed {
        logic req;   // wrote 0
        logic rel;   // wrote 1
    } port_cmd_t;

    // Queued-request update for a side that does not hold the flag.
    function automatic logic wait_next(logic cur, port_cmd_t c);
        if (c.req)
            return 1'b1;
        else if (c.rel)
            return 1'b0;
        else
            return cur;
    endfunction

    function automatic flag_st_t next_flag(flag_st_t s, port_cmd_t l, port_cmd_t r);
        flag_st_t n;
        logic     w;
        n = s;
        case (s.holder)
            TOK_FREE: begin
                n.wait_l = 1'b0;
                n.wait_r = 1'b0;
                if (l.req) begin
                    n.holder = TOK_LEFT;
                    n.wait_r = r.req;
                end else if (r.req) begin
                    n.holder = TOK_RIGHT;
                end
            end
            TOK_LEFT: begin
                w        = wait_next(s.wait_r, r);
                n.wait_l = 1'b0;
                if (l.rel) begin
                    n.holder = w ? TOK_RIGHT : TOK_FREE;
                    n.wait_r = 1'b0;
                end else begin
                    n.wait_r = w;
                end
            end
            TOK_RIGHT: begin
                w        = wait_next(s.wait_l, l);
                n.wait_r = 1'b0;
                if (r.rel) begin
                    n.holder = w ? TOK_LEFT : TOK_FREE;
                    n.wait_l = 1'b0;
                end else begin
                    n.wait_l = w;
                end
            end
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int N_FLAGS = SEM_FLAGS,
    localparam int AW     = $clog2(N_FLAGS)
) (
    input  logic                      sel_n,
    input  logic                      ce_n,
    input  logic                      we_n,
    input  logic [AW-1:0]             addr,
    input  logic                      wbit,
    output port_cmd_t [N_FLAGS-1:0]   cmd,
    output logic                      rd_en
);

    logic access;
    logic wr_en;

    assign access = ~sel_n & ce_n;
    assign wr_en  = access & ~we_n;
    assign rd_en  = access & we_n;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_cmd
        logic hit;
        assign hit        = wr_en && (addr == AW'(g));
        assign cmd[g].req = hit & ~wbit;
        assign cmd[g].rel = hit &  wbit;
    end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_cmd_t l_cmd,
    input  port_cmd_t r_cmd,
    output logic      own_l,
    output logic      own_r
);

    flag_st_t st;

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else
            st <= next_flag(st, l_cmd, r_cmd);
    end

    assign own_l = (st.holder == TOK_LEFT);
    assign own_r = (st.holder == TOK_RIGHT);

    AST_FREE_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (st.holder == TOK_FREE && l_cmd.req) |=> own_l); // R3

    AST_HELD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (own_l && r_cmd.req && !l_cmd.rel) |=> (own_l && st.wait_r)); // R4

    AST_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        (own_l && l_cmd.rel && (st.wait_r || r_cmd.req) && !r_cmd.rel) |=> own_r); // R5

    AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (rst)
        (own_r && r_cmd.rel && !st.wait_l && !l_cmd.req) |=> (st.holder == TOK_FREE)); // R6

    AST_CANCEL_WAIT: assert property (@(posedge clk) disable iff (rst)
        (own_l && r_cmd.rel && !l_cmd.rel) |=> (own_l && !st.wait_r)); // R8

    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
        (st.holder == TOK_FREE && l_cmd.req && r_cmd.req) |=> (own_l && st.wait_r)); // R9

    AST_WAIT_NEEDS_HOLDER: assert property (@(posedge clk) disable iff (rst)
        st.wait_r |-> own_l); // R4

endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux
    import sem_pkg::*;
#(
    parameter int N_FLAGS = SEM_FLAGS,
    parameter int DW      = SEM_DW,
    localparam int AW     = $clog2(N_FLAGS)
) (
    input  logic [N_FLAGS-1:0] own,
    input  logic [AW-1:0]      addr,
    input  logic               rd_en,
    output logic [DW-1:0]      rdata
);

    always_comb begin
        if (rd_en)
            rdata = {DW{~own[addr]}};
        else
            rdata = '0;
    end

endmodule

// File: rtl/dual_sem_unit.sv
module dual_sem_unit
    import sem_pkg::*;
#(
    parameter int N_FLAGS = SEM_FLAGS,
    parameter int DW      = SEM_DW,
    localparam int AW     = $clog2(N_FLAGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_sel_n,
    input  logic          l_ce_n,
    input  logic          l_we_n,
    input  logic [AW-1:0] l_addr,
    input  logic          l_wbit,
    output logic [DW-1:0] l_rdata,
    input  logic          r_sel_n,
    input  logic          r_ce_n,
    input  logic          r_we_n,
    input  logic [AW-1:0] r_addr,
    input  logic          r_wbit,
    output logic [DW-1:0] r_rdata
);

    port_cmd_t [N_FLAGS-1:0] l_cmd;
    port_cmd_t [N_FLAGS-1:0] r_cmd;
    logic                    l_rd;
    logic                    r_rd;
    logic [N_FLAGS-1:0]      own_l;
    logic [N_FLAGS-1:0]      own_r;

    sem_port_decode #(.N_FLAGS(N_FLAGS)) u_dec_l (
        .sel_n (l_sel_n),
        .ce_n  (l_ce_n),
        .we_n  (l_we_n),
        .addr  (l_addr),
        .wbit  (l_wbit),
        .cmd   (l_cmd),
        .rd_en (l_rd)
    );

    sem_port_decode #(.N_FLAGS(N_FLAGS)) u_dec_r (
        .sel_n (r_sel_n),
        .ce_n  (r_ce_n),
        .we_n  (r_we_n),
        .addr  (r_addr),
        .wbit  (r_wbit),
        .cmd   (r_cmd),
        .rd_en (r_rd)
    );

    for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
        sem_flag_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .l_cmd (l_cmd[f]),
            .r_cmd (r_cmd[f]),
            .own_l (own_l[f]),
            .own_r (own_r[f])
        );
    end

    sem_read_mux #(.N_FLAGS(N_FLAGS), .DW(DW)) u_rd_l (
        .own   (own_l),
        .addr  (l_addr),
        .rd_en (l_rd),
        .rdata (l_rdata)
    );

    sem_read_mux #(.N_FLAGS(N_FLAGS), .DW(DW)) u_rd_r (
        .own   (own_r),
        .addr  (r_addr),
        .rd_en (r_rd),
        .rdata (r_rdata)
    );

    AST_READ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        l_rd |-> ($countones(l_rdata) == 0 || $countones(l_rdata) == DW)); // R7

    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (l_ce_n == 1'b0) |-> (l_rdata == '0)); // R2

    AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (rst)
        (own_l & own_r) == '0); // R1

endmodule

// File: tb/test_dual_sem_unit.sv
module test_dual_sem_unit;

    localparam int NF = 8;
    localparam int DW = 16;
    localparam int OP_IDLE = 0, OP_RD = 1, OP_W0 = 2, OP_W1 = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          l_sel_n = 1'b1, l_ce_n = 1'b1, l_we_n = 1'b1, l_wbit = 1'b0;
    logic          r_sel_n = 1'b1, r_ce_n = 1'b1, r_we_n = 1'b1, r_wbit = 1'b0;
    logic [2:0]    l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;

    // reference model: 0 free, 1 left, 2 right
    int m_own [NF];
    bit m_wl  [NF];
    bit m_wr  [NF];

    always #10 clk = ~clk;

    dual_sem_unit i_dual_sem_unit (
        .clk(clk), .rst(rst),
        .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n),
        .l_addr(l_addr), .l_wbit(l_wbit), .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n),
        .r_addr(r_addr), .r_wbit(r_wbit), .r_rdata(r_rdata)
    );

    function automatic logic [DW-1:0] exp_read(int op, bit bad, int own, int me);
        if (op != OP_RD || bad) return '0;
        return (own == me) ? '0 : '1;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_update(int lop, int la, bit lbad, int rop, int ra, bit rbad);
        for (int f = 0; f < NF; f++) begin
            bit lq, lr, rq, rr, w;
            lq = !lbad && la == f && lop == OP_W0;
            lr = !lbad && la == f && lop == OP_W1;
            rq = !rbad && ra == f && rop == OP_W0;
            rr = !rbad && ra == f && rop == OP_W1;
            if (m_own[f] == 0) begin
                if (lq) begin m_own[f] = 1; m_wr[f] = rq; end
                else if (rq) m_own[f] = 2;
            end else if (m_own[f] == 1) begin
                w = rq ? 1'b1 : (rr ? 1'b0 : m_wr[f]);
                if (lr) begin m_own[f] = w ? 2 : 0; m_wr[f] = 1'b0; end
                else m_wr[f] = w;
            end else begin
                w = lq ? 1'b1 : (lr ? 1'b0 : m_wl[f]);
                if (rr) begin m_own[f] = w ? 1 : 0; m_wl[f] = 1'b0; end
                else m_wl[f] = w;
            end
        end
    endtask

    task automatic step(int lop, int la, bit lbad, int rop, int ra, bit rbad, string tag);
        @(negedge clk);
        l_sel_n = (lop == OP_IDLE); l_ce_n = ~lbad; l_we_n = !(lop == OP_W0 || lop == OP_W1);
        l_wbit = (lop == OP_W1); l_addr = 3'(la);
        r_sel_n = (rop == OP_IDLE); r_ce_n = ~rbad; r_we_n = !(rop == OP_W0 || rop == OP_W1);
        r_wbit = (rop == OP_W1); r_addr = 3'(ra);
        #1;
        if (lop == OP_RD) check({tag, " left read"},  l_rdata, exp_read(lop, lbad, m_own[la], 1));
        if (rop == OP_RD) check({tag, " right read"}, r_rdata, exp_read(rop, rbad, m_own[ra], 2));
        @(posedge clk);
        model_update(lop, la, lbad, rop, ra, rbad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int f = 0; f < NF; f++) begin m_own[f] = 0; m_wl[f] = 0; m_wr[f] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R7: after reset every flag reads as not held
        for (int f = 0; f < NF; f++) step(OP_RD, f, 0, OP_RD, f, 0, "R7");

        // R3: claim of a free flag
        step(OP_W0, 2, 0, OP_IDLE, 0, 0, "R3");
        step(OP_RD, 2, 0, OP_RD, 2, 0, "R3");
        // R4: blocked claim from the other side
        step(OP_IDLE, 0, 0, OP_W0, 2, 0, "R4");
        step(OP_RD, 2, 0, OP_RD, 2, 0, "R4");
        // R10: holder claims again
        step(OP_W0, 2, 0, OP_IDLE, 0, 0, "R10");
        step(OP_RD, 2, 0, OP_RD, 2, 0, "R10");
        // R5: release hands over to the queued side
        step(OP_W1, 2, 0, OP_IDLE, 0, 0, "R5");
        step(OP_RD, 2, 0, OP_RD, 2, 0, "R5");
        // R6: release with nothing queued
        step(OP_IDLE, 0, 0, OP_W1, 2, 0, "R6");
        step(OP_RD, 2, 0, OP_RD, 2, 0, "R6");
        // R5: same-cycle request and release
        step(OP_W0, 4, 0, OP_IDLE, 0, 0, "R5");
        step(OP_W1, 4, 0, OP_W0, 4, 0, "R5");
        step(OP_RD, 4, 0, OP_RD, 4, 0, "R5");
        step(OP_IDLE, 0, 0, OP_W1, 4, 0, "R6");
        // R8: cancelled request, then release frees
        step(OP_W0, 3, 0, OP_W0, 3, 0, "R9");
        step(OP_IDLE, 0, 0, OP_W1, 3, 0, "R8");
        step(OP_W1, 3, 0, OP_RD, 3, 0, "R8");
        step(OP_RD, 3, 0, OP_RD, 3, 0, "R8");
        // R8: release of an unheld free flag has no effect
        step(OP_W1, 5, 0, OP_RD, 5, 0, "R8");
        step(OP_RD, 5, 0, OP_W0, 5, 0, "R8");
        step(OP_RD, 5, 0, OP_RD, 5, 0, "R8");
        step(OP_IDLE, 0, 0, OP_W1, 5, 0, "R8");
        // R9: tie on a free flag
        step(OP_W0, 6, 0, OP_W0, 6, 0, "R9");
        step(OP_RD, 6, 0, OP_RD, 6, 0, "R9");
        step(OP_W1, 6, 0, OP_IDLE, 0, 0, "R9");
        step(OP_RD, 6, 0, OP_RD, 6, 0, "R9");
        step(OP_IDLE, 0, 0, OP_W1, 6, 0, "R9");
        // R2: memory enable active blocks writes and reads
        step(OP_W0, 1, 1, OP_IDLE, 0, 0, "R2");
        step(OP_RD, 1, 1, OP_RD, 1, 0, "R2");
        step(OP_RD, 1, 0, OP_RD, 1, 1, "R2");
        // R1: one flag held, others untouched
        step(OP_W0, 0, 0, OP_IDLE, 0, 0, "R1");
        for (int f = 0; f < NF; f++) step(OP_RD, f, 0, OP_RD, f, 0, "R1");
        step(OP_W1, 0, 0, OP_IDLE, 0, 0, "R1");

        // random phase, fixed seed, addresses biased for contention
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            int lop, rop, la, ra;
            bit lb, rb;
            lop = $urandom_range(0, 3);
            rop = $urandom_range(0, 3);
            la  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : $urandom_range(0, 1);
            ra  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : $urandom_range(0, 1);
            lb  = ($urandom_range(0, 7) == 0);
            rb  = ($urandom_range(0, 7) == 0);
            step(lop, la, lb, rop, ra, rb, "R1 R7 random");
        end
        for (int f = 0; f < NF; f++) step(OP_RD, f, 0, OP_RD, f, 0, "R7 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule